// File: doc/BRIEF.md
# Expansion-Bit Address Match Filter

This block sits after a UART receiver that can deliver 9-bit characters. The ninth bit of each character is an expansion marker. For every completed character it decides which event to raise: a receive-complete pulse for ordinary data, a status pulse for an address character that matches a stored ID, or no event at all. A host loads the stored ID through a write strobe. A sticky match flag records that a matching address was seen.

Filtering applies only when three settings are all on: 9-bit length, expansion mode and compare enable. In that case a character is treated as an address when its expansion bit equals a programmable level. An address that matches the ID raises the status pulse and updates the received-data register. An address that does not match is dropped silently. Any character whose expansion bit differs from the level is treated as data. In every other configuration, each character raises the receive-complete pulse. All outputs are registered, so each event appears in the clock cycle after the character strobe.

Top module: `exb_addr_filter`

## Requirements
- R1: During and directly after reset, `rc_pulse`, `st_pulse` and `match_flag` are 0, `rd_data` is 0x00 and the stored ID is 0x00. A matching address 0x00 received before any ID write therefore produces a status pulse.
- R2: When `cfg_cmp_en` is 0, every `rx_valid` cycle gives `rc_pulse` = 1 in the next cycle, with `rd_data` equal to the received byte.
- R3: When `cfg_cmp_en` is 1 but `cfg_nine` or `cfg_xbit_en` is 0, the compare has no effect. Every character gives `rc_pulse` and updates `rd_data`, whatever its expansion bit or value.
- R4: When compare is active and `rx_xbit` differs from `cfg_xbit_lvl`, the character gives `rc_pulse` in the next cycle and updates `rd_data`.
- R5: When compare is active, `rx_xbit` equals `cfg_xbit_lvl` and `rx_data` equals the stored ID, the next cycle has `st_pulse` = 1, `rc_pulse` = 0, `rd_data` equal to the byte and `match_flag` = 1.
- R6: When compare is active, `rx_xbit` equals `cfg_xbit_lvl` and `rx_data` differs from the stored ID, no pulse is raised and `rd_data` keeps its value.
- R7: `id_wr` loads `id_wdata` into the stored ID at the clock edge. A character strobed in the same cycle is compared against the old ID.
- R8: `match_flag` stays set until a cycle with `match_clr` = 1. If `match_clr` and a new match occur in the same cycle, the flag stays set.
- R9: Each pulse is high for exactly one cycle per character. `rc_pulse` and `st_pulse` are never high together. No pulse follows a cycle without `rx_valid`.
- R10: The address level is selectable. With `cfg_xbit_lvl` = 0, characters with expansion bit 0 are compared and characters with expansion bit 1 are data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a completed character |
| rx_data | input | 8 | Received data byte |
| rx_xbit | input | 1 | Received expansion (ninth) bit |
| cfg_nine | input | 1 | 9-bit character length selected |
| cfg_xbit_en | input | 1 | Expansion-bit mode enabled |
| cfg_cmp_en | input | 1 | Address compare enabled |
| cfg_xbit_lvl | input | 1 | Expansion-bit level that marks an address |
| id_wr | input | 1 | Stored ID write strobe |
| id_wdata | input | 8 | Value written to the stored ID |
| match_clr | input | 1 | Clears the sticky match flag |
| rc_pulse | output | 1 | Receive-complete event pulse |
| st_pulse | output | 1 | Status (address match) event pulse |
| match_flag | output | 1 | Sticky address-match flag |
| rd_data | output | 8 | Received-data register |

## Verification
The bench targets four corner cases.

- Compare enabled while 9-bit length or expansion mode is off. A design that misread this would drop or reroute characters that should raise receive-complete.
- An ID write in the same cycle as a matching character. A design that compared against the new value would raise a status pulse where none is due.
- A clear strobe that lands on a match. A design with the wrong priority would leave the flag at 0.
- Non-matching address characters. A design that updated the data register on a miss would show a changed `rd_data` with no pulse beside it.

Both address levels run against randomly mixed traffic. Each traffic mix has many IDs equal to the current ID, so that matches are frequent.

// File: rtl/exbf_pkg.sv
package exbf_pkg;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_DATA     = 2'd1,
    EV_ADDR_HIT = 2'd2
  } ev_kind_e;

  // Compare is only live when all three configuration bits are on.
  function automatic logic exbf_cmp_live(input logic nine, input logic xen,
                                         input logic cmp);
    return nine & xen & cmp;
  endfunction

  // Route one completed character to an event kind.
  function automatic ev_kind_e exbf_route(input logic valid, input logic live,
                                          input logic xbit, input logic lvl,
                                          input logic id_eq);
    ev_kind_e k;
    k = EV_NONE;
    if (valid) begin
      if (!live || (xbit != lvl)) k = EV_DATA;
      else if (id_eq)             k = EV_ADDR_HIT;
      else                        k = EV_NONE;
    end
    return k;
  endfunction

endpackage

// File: rtl/exbf_id_reg.sv
module exbf_id_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] id_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  id_q <= '0;
    else if (wr) id_q <= wdata;
  end
endmodule

// File: rtl/exbf_classify.sv
module exbf_classify
  import exbf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         valid,
  input  logic [W-1:0] data,
  input  logic         xbit,
  input  logic         nine,
  input  logic         xen,
  input  logic         cmp,
  input  logic         lvl,
  input  logic [W-1:0] id_q,
  output ev_kind_e     kind,
  output logic         live
);
  logic [W-1:0] bit_eq;
  logic         id_eq;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_cmp
      assign bit_eq[gi] = ~(data[gi] ^ id_q[gi]);
    end
  endgenerate

  assign id_eq = &bit_eq;
  assign live  = exbf_cmp_live(nine, xen, cmp);

  always_comb begin
    kind = exbf_route(valid, live, xbit, lvl, id_eq);
  end
endmodule

// File: rtl/exbf_event_reg.sv
module exbf_event_reg
  import exbf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ev_kind_e     kind,
  input  logic [W-1:0] data,
  input  logic         clr,
  output logic         rc_pulse,
  output logic         st_pulse,
  output logic         flag,
  output logic [W-1:0] rd_q
);
  logic take;
  assign take = (kind == EV_DATA) || (kind == EV_ADDR_HIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_pulse <= 1'b0;
      st_pulse <= 1'b0;
    end else begin
      rc_pulse <= (kind == EV_DATA);
      st_pulse <= (kind == EV_ADDR_HIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_q <= '0;
    else if (take) rd_q <= data;
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag <= 1'b0;
    else if (kind == EV_ADDR_HIT)  flag <= 1'b1;
    else if (clr)                  flag <= 1'b0;
  end
endmodule

// File: rtl/exb_addr_filter.sv
module exb_addr_filter
  import exbf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_xbit,
  input  logic         cfg_nine,
  input  logic         cfg_xbit_en,
  input  logic         cfg_cmp_en,
  input  logic         cfg_xbit_lvl,
  input  logic         id_wr,
  input  logic [W-1:0] id_wdata,
  input  logic         match_clr,
  output logic         rc_pulse,
  output logic         st_pulse,
  output logic         match_flag,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] id_q;
  ev_kind_e     ev_kind;
  logic         cmp_live;

  exbf_id_reg #(.W(W)) u_id (
    .clk(clk), .rst_n(rst_n), .wr(id_wr), .wdata(id_wdata), .id_q(id_q)
  );

  exbf_classify #(.W(W)) u_cls (
    .valid(rx_valid), .data(rx_data), .xbit(rx_xbit),
    .nine(cfg_nine), .xen(cfg_xbit_en), .cmp(cfg_cmp_en), .lvl(cfg_xbit_lvl),
    .id_q(id_q), .kind(ev_kind), .live(cmp_live)
  );

  exbf_event_reg #(.W(W)) u_ev (
    .clk(clk), .rst_n(rst_n), .kind(ev_kind), .data(rx_data), .clr(match_clr),
    .rc_pulse(rc_pulse), .st_pulse(st_pulse), .flag(match_flag), .rd_q(rd_data)
  );
endmodule

// File: rtl/exbf_checker.sv
module exbf_checker
  import exbf_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         rx_xbit,
  input logic         cfg_nine,
  input logic         cfg_xbit_en,
  input logic         cfg_cmp_en,
  input logic         cfg_xbit_lvl,
  input logic         id_wr,
  input logic [W-1:0] id_wdata,
  input logic         match_clr,
  input logic         rc_pulse,
  input logic         st_pulse,
  input logic         match_flag,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] id_q,
  input ev_kind_e     ev_kind,
  input logic         cmp_live
);
  logic full_mode;
  assign full_mode = cfg_nine && cfg_xbit_en && cfg_cmp_en;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rc_pulse && st_pulse));

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!rc_pulse && !st_pulse));

  a_r2_cmp_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_cmp_en) |=> (rc_pulse && rd_data == $past(rx_data)));

  a_r3_partial_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_cmp_en && !(cfg_nine && cfg_xbit_en)) |=> rc_pulse);

  a_r4_data_char: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full_mode && rx_xbit != cfg_xbit_lvl) |=> rc_pulse);

  a_r5_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full_mode && rx_xbit == cfg_xbit_lvl && rx_data == id_q)
      |=> (st_pulse && match_flag));

  a_r6_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full_mode && rx_xbit == cfg_xbit_lvl && rx_data != id_q)
      |=> (!rc_pulse && !st_pulse && $stable(rd_data)));

  a_r7_id_load: assert property (@(posedge clk) disable iff (!rst_n)
    id_wr |=> (id_q == $past(id_wdata)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (match_clr && ev_kind != EV_ADDR_HIT) |=> !match_flag);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);

  a_r3_live_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_live |-> (cfg_nine && cfg_xbit_en));
endmodule

bind exb_addr_filter exbf_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_xbit(rx_xbit), .cfg_nine(cfg_nine), .cfg_xbit_en(cfg_xbit_en),
  .cfg_cmp_en(cfg_cmp_en), .cfg_xbit_lvl(cfg_xbit_lvl), .id_wr(id_wr),
  .id_wdata(id_wdata), .match_clr(match_clr), .rc_pulse(rc_pulse),
  .st_pulse(st_pulse), .match_flag(match_flag), .rd_data(rd_data),
  .id_q(id_q), .ev_kind(ev_kind), .cmp_live(cmp_live)
);

// File: tb/tb_exb_addr_filter.sv
module tb_exb_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, rx_xbit = 0;
  logic [7:0] rx_data = 0, id_wdata = 0;
  logic       cfg_nine = 0, cfg_xbit_en = 0, cfg_cmp_en = 0, cfg_xbit_lvl = 0;
  logic       id_wr = 0, match_clr = 0;
  logic       rc_pulse, st_pulse, match_flag;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  exb_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_xbit(rx_xbit), .cfg_nine(cfg_nine), .cfg_xbit_en(cfg_xbit_en),
    .cfg_cmp_en(cfg_cmp_en), .cfg_xbit_lvl(cfg_xbit_lvl), .id_wr(id_wr),
    .id_wdata(id_wdata), .match_clr(match_clr), .rc_pulse(rc_pulse),
    .st_pulse(st_pulse), .match_flag(match_flag), .rd_data(rd_data)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit running = 0;

  task automatic chk(input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model: behavioural restatement of R1..R10
  int    m_id, m_rd;
  bit    m_rc, m_st, m_flag;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_id = 0; m_rd = 0; m_rc = 0; m_st = 0; m_flag = 0; m_tag = "R1";
    end else begin
      bit hit;
      hit = 0; m_rc = 0; m_st = 0;
      if (!rx_valid) m_tag = "R9";
      else if (!cfg_cmp_en) begin m_tag = "R2"; m_rc = 1; m_rd = rx_data; end
      else if (!(cfg_nine && cfg_xbit_en)) begin m_tag = "R3"; m_rc = 1; m_rd = rx_data; end
      else if (rx_xbit != cfg_xbit_lvl) begin
        m_tag = cfg_xbit_lvl ? "R4" : "R10"; m_rc = 1; m_rd = rx_data;
      end else if (int'(rx_data) == m_id) begin
        m_tag = cfg_xbit_lvl ? "R5" : "R10"; m_st = 1; hit = 1; m_rd = rx_data;
      end else m_tag = cfg_xbit_lvl ? "R6" : "R10";
      if (rx_valid && id_wr) m_tag = "R7";   // compared against the old ID
      if (hit) m_flag = 1;
      else if (match_clr) m_flag = 0;
      if (id_wr) m_id = id_wdata;
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk(m_tag, "rc_pulse", rc_pulse, m_rc);
      chk(m_tag, "st_pulse", st_pulse, m_st);
      chk(m_tag, "rd_data", rd_data, m_rd);
      chk("R8", "match_flag", match_flag, m_flag);
      if (rc_pulse && st_pulse) chk("R9", "both pulses", 1, 0);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      mismatched++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      finish_run();
    end
  end

  task automatic idle();
    rx_valid = 0; id_wr = 0; match_clr = 0;
    @(negedge clk);
  endtask

  task automatic rx(input logic [7:0] d, input logic x);
    rx_valid = 1; rx_data = d; rx_xbit = x; id_wr = 0; match_clr = 0;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic cfg(input logic n, input logic e, input logic c, input logic l);
    cfg_nine = n; cfg_xbit_en = e; cfg_cmp_en = c; cfg_xbit_lvl = l;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "rc_pulse", rc_pulse, 0);
    chk("R1", "st_pulse", st_pulse, 0);
    chk("R1", "match_flag", match_flag, 0);
    chk("R1", "rd_data", rd_data, 0);
    rst_n = 1; running = 1;
    idle();
    // R1: ID resets to 0x00, so address 0x00 matches
    cfg(1, 1, 1, 1);
    rx(8'h00, 1); idle();
    match_clr = 1; idle();
    // R2: compare off
    cfg(1, 1, 0, 1);
    rx(8'h33, 1); rx(8'h44, 0);
    // R3: compare on, mode partial
    cfg(0, 1, 1, 1); rx(8'h77, 1);
    cfg(1, 0, 1, 1); rx(8'h78, 1);
    // R7: ID write together with matching character
    cfg(1, 1, 1, 1);
    rx_valid = 1; rx_data = 8'h5A; rx_xbit = 1; id_wr = 1; id_wdata = 8'h5A;
    @(negedge clk); idle();
    rx(8'h5A, 1);          // R5 hit
    rx(8'h5B, 1);          // R6 miss
    rx(8'h5B, 0);          // R4 data
    // R8: set and clear same cycle
    rx_valid = 1; rx_data = 8'h5A; rx_xbit = 1; match_clr = 1;
    @(negedge clk); idle();
    match_clr = 1; idle(); idle();
    // R10: level 0
    cfg(1, 1, 1, 0);
    rx(8'h5A, 0); rx(8'h11, 0); rx(8'h11, 1);
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) cfg(1, 1, 1, i[9]);
      if ($urandom_range(0, 9) == 0)
        cfg($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) != 0, cfg_xbit_lvl);
      rx_valid = $urandom_range(0, 2) != 0;
      rx_xbit  = $urandom_range(0, 1) != 0;
      rx_data  = ($urandom_range(0, 1) != 0) ? 8'(m_id) : 8'($urandom_range(0, 255));
      id_wr    = $urandom_range(0, 15) == 0;
      id_wdata = 8'($urandom_range(0, 255));
      match_clr = $urandom_range(0, 7) == 0;
      @(negedge clk);
    end
    idle(); idle();
    finish_run();
  end
endmodule